// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block holds the interrupt event state of one serial channel. Each event line from the receive side, the transmit side or the line logic sets its own sticky bit in a 32-bit status word. Software reads that word to poll for events and writes ones to acknowledge them. A second register holds an enable mask. The registered interrupt output is high whenever an unmasked status bit is set.

The block also works out transmit overflow itself. It compares the width of each push into the transmit FIFO with the FIFO's fill flags. A push while the FIFO is full sets the overflow bit. A two-byte push while only one slot is free sets it as well.

Software reaches both registers through a simple register bus. The bus has an address, a write strobe, write data qualified by byte enables, and read data that follows the address combinationally.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the status register, the mask register and `irq` are all zero.
- R2: A high level on `evt[i]` (i = 0..11) during a clock edge sets status bit i, and the bit stays set after the event line drops. Bit 0 is the RX trigger-level event, bit 1 is RX empty and bit 2 is RX full.
- R3: A write to the status address (0x14) clears each status bit whose data bit is 1 and whose byte lane is enabled (`wr_be[k]` covers bits 8k+7..8k). Bits written with 0, and bits in disabled lanes, are unchanged.
- R4: Bits 31..13 of both registers always read as zero, and writes to them have no effect.
- R5: Status bit 12 (TX overflow) sets when `tx_push` is high while `tx_full` is high.
- R6: Status bit 12 also sets when `tx_push` and `tx_push_two` are both high while `tx_nearly_full` is high. A one-byte push with only `tx_nearly_full` high does not set it, and neither does a two-byte push with neither flag high.
- R7: Status bits set even when their mask bit is 0. `irq` equals the OR of (status AND mask) as those registers stood one clock edge earlier.
- R8: If an event and a software clear hit the same status bit at the same edge, the bit ends up set.
- R9: The mask register at address 0x08 is read/write through byte lanes (bits 12..0). Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte enables for the write data |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| evt | input | 12 | Event levels for status bits 11..0 |
| tx_push | input | 1 | A push into the TX FIFO happens this cycle |
| tx_push_two | input | 1 | The push carries two bytes |
| tx_full | input | 1 | TX FIFO has no free slot |
| tx_nearly_full | input | 1 | TX FIFO has exactly one free slot |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims at overflow detection by push width. A design that ignored `tx_push_two` would miss the two-byte case. One that treated the nearly-full flag alone as overflow would flag harmless one-byte pushes. It pairs an event with a clear of the same bit, where a design that lets the clear win would drop an event. It also writes ones into disabled byte lanes and into reserved bits, where a design with wrong lane decoding would clear or store bits it should not. Finally, it times `irq` against mask and status changes, which catches an output that is combinational or one cycle too late.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int NEV       = 12,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 'h14,
  parameter int MASK_ADDR = 'h08
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [DATA_W/8-1:0]   wr_be,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NEV-1:0]        evt,
  input  logic                  tx_push,
  input  logic                  tx_push_two,
  input  logic                  tx_full,
  input  logic                  tx_nearly_full,
  output logic                  irq
);
  localparam int SW  = NEV + 1;
  localparam int OVF = NEV;
  localparam int NB  = DATA_W / 8;

  logic [SW-1:0]     sts_q, mask_q, set_v, clr_v, lane_v;
  logic [DATA_W-1:0] be_bits;
  logic              hit_sts, hit_mask, ovf;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign be_bits[8*b +: 8] = {8{wr_be[b]}};
  end

  assign lane_v   = be_bits[SW-1:0];
  assign hit_sts  = wr_en && (addr == ADDR_W'(STAT_ADDR));
  assign hit_mask = wr_en && (addr == ADDR_W'(MASK_ADDR));
  assign ovf      = tx_push && (tx_full || (tx_push_two && tx_nearly_full));
  assign set_v    = {ovf, evt};
  assign clr_v    = hit_sts ? (wr_data[SW-1:0] & lane_v) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_v) | set_v;
      if (hit_mask)
        mask_q <= (mask_q & ~lane_v) | (wr_data[SW-1:0] & lane_v);
      irq <= |(sts_q & mask_q);
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(STAT_ADDR))      rd_data[SW-1:0] = sts_q;
    else if (addr == ADDR_W'(MASK_ADDR)) rd_data[SW-1:0] = mask_q;
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts_q[NEV-1:0] & $past(evt)) == $past(evt)));

  p_clear_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(STAT_ADDR) && wr_be[0] && wr_data[0] && !evt[0]) |=> !sts_q[0]);

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:SW] == '0);

  p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full) |=> sts_q[OVF]);

  p_ovf_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_push_two && tx_nearly_full) |=> sts_q[OVF]);

  p_irq_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(sts_q) & $past(mask_q))));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(STAT_ADDR) && wr_be[0] && wr_data[0] && evt[0]) |=> sts_q[0]);
endmodule

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb;
  localparam logic [5:0] A_STS = 6'h14;
  localparam logic [5:0] A_MSK = 6'h08;
  localparam logic [5:0] A_NONE = 6'h20;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        irq;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic [5:0]  addr = '0;
  logic        wr_en = 0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [11:0] evt = '0;
  logic        tx_push = 0, tx_push_two = 0, tx_full = 0, tx_nearly_full = 0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];
  logic [12:0] m_sts = '0, m_msk = '0;
  logic        m_irq = 0;

  always #4 clk = ~clk;

  uart_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .evt(evt), .tx_push(tx_push),
    .tx_push_two(tx_push_two), .tx_full(tx_full), .tx_nearly_full(tx_nearly_full),
    .irq(irq));

  function automatic logic [12:0] lanes(logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m[12:0];
  endfunction

  task automatic drive(string tag, logic [5:0] a, logic we, logic [31:0] d, logic [3:0] be,
                       logic [11:0] ev, logic push, logic two, logic full, logic nf);
    exp_t e;
    logic nxt_irq;
    logic ov;
    @(negedge clk); #1;
    addr = a; wr_en = we; wr_data = d; wr_be = be; evt = ev;
    tx_push = push; tx_push_two = two; tx_full = full; tx_nearly_full = nf;
    nxt_irq = |(m_sts & m_msk);
    ov = push && (full || (two && nf));
    if (we && a == A_STS) m_sts = m_sts & ~(d[12:0] & lanes(be));
    m_sts = m_sts | {ov, ev};
    if (we && a == A_MSK) m_msk = (m_msk & ~lanes(be)) | (d[12:0] & lanes(be));
    m_irq = nxt_irq;
    e.tag = tag;
    e.irq = m_irq;
    e.rd  = (a == A_STS) ? {19'd0, m_sts} : (a == A_MSK) ? {19'd0, m_msk} : 32'd0;
    q.push_back(e);
  endtask

  task automatic rd(string tag, logic [5:0] a);
    drive(tag, a, 0, '0, '0, '0, 0, 0, 0, 0);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (rd_data !== e.rd || irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                 e.tag, rd_data, irq, e.rd, e.irq);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd("R1 status reset", A_STS);
    rd("R1 mask reset", A_MSK);
    drive("R2 set bit0", A_STS, 0, '0, '0, 12'h001, 0, 0, 0, 0);
    rd("R2 sticky bit0", A_STS);
    drive("R2 set bits 1,2,5,11", A_STS, 0, '0, '0, 12'h826, 0, 0, 0, 0);
    rd("R2 sticky several", A_STS);
    drive("R3 clear bit0", A_STS, 1, 32'h1, 4'b0001, '0, 0, 0, 0, 0);
    drive("R3 zeros keep", A_STS, 1, 32'h0, 4'b1111, '0, 0, 0, 0, 0);
    drive("R3 lane off keeps bit11", A_STS, 1, 32'h800, 4'b0001, '0, 0, 0, 0, 0);
    drive("R3 lane on clears bit11", A_STS, 1, 32'h800, 4'b0010, '0, 0, 0, 0, 0);
    drive("R4 reserved status write", A_STS, 1, 32'hFFFF_E000, 4'b1111, '0, 0, 0, 0, 0);
    drive("R4 R9 mask all ones", A_MSK, 1, 32'hFFFF_FFFF, 4'b1111, '0, 0, 0, 0, 0);
    drive("R9 mask byte1 only", A_MSK, 1, 32'h0000_0000, 4'b0010, '0, 0, 0, 0, 0);
    drive("R9 mask clear", A_MSK, 1, 32'h0, 4'b1111, '0, 0, 0, 0, 0);
    rd("R9 other address zero", A_NONE);
    drive("R3 clear all", A_STS, 1, 32'hFFFF_FFFF, 4'b1111, '0, 0, 0, 0, 0);
    drive("R5 push when full", A_STS, 0, '0, '0, '0, 1, 0, 1, 0);
    rd("R5 overflow sticky", A_STS);
    drive("R3 clear ovf", A_STS, 1, 32'h1000, 4'b0010, '0, 0, 0, 0, 0);
    drive("R5 full no push", A_STS, 0, '0, '0, '0, 0, 1, 1, 1);
    drive("R6 one byte nearly full", A_STS, 0, '0, '0, '0, 1, 0, 0, 1);
    drive("R6 two bytes free room", A_STS, 0, '0, '0, '0, 1, 1, 0, 0);
    drive("R6 two bytes nearly full", A_STS, 0, '0, '0, '0, 1, 1, 0, 1);
    rd("R6 overflow seen", A_STS);
    drive("R3 clear ovf again", A_STS, 1, 32'h1000, 4'b0010, '0, 0, 0, 0, 0);
    drive("R7 masked-off event polled", A_STS, 0, '0, '0, 12'h002, 0, 0, 0, 0);
    rd("R7 no irq while masked", A_STS);
    drive("R7 enable bit1", A_MSK, 1, 32'h2, 4'b0001, '0, 0, 0, 0, 0);
    rd("R7 irq one cycle later", A_STS);
    rd("R7 irq held", A_MSK);
    drive("R7 clear bit1", A_STS, 1, 32'h2, 4'b0001, '0, 0, 0, 0, 0);
    rd("R7 irq drops", A_STS);
    drive("R8 event and clear same edge", A_STS, 1, 32'h2, 4'b0001, 12'h002, 0, 0, 0, 0);
    rd("R8 bit kept", A_STS);
    drive("R8 ovf and clear same edge", A_STS, 1, 32'h1000, 4'b0010, '0, 1, 0, 1, 0);
    rd("R8 ovf kept", A_STS);
    rd("R7 final", A_STS);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule